// File: doc/BRIEF.md
# PWM Output Stage with Dead Time and Override Chain

This block sits at the end of one PWM channel. It turns a single raw PWM waveform into a high-side and a low-side pin drive. Three pin modes are available. In complementary mode the low pin is the inverse of the raw signal, and each side's turn-on is held back by its own programmable dead time. In independent mode both pins copy the raw signal. In push-pull mode the raw pulse alternates between the two pins from one timebase cycle to the next, with no dead time.

Every pin pair then passes through a fixed-priority override chain. The levels, from strongest to weakest, are debug halt, fault, current limit, feed-forward and software override. Each level supplies its own two-bit pin state. The software override is double-buffered. A write lands in a staging copy, which the next start-of-cycle pulse copies into the live copy, or the write takes effect at once when the immediate setting is selected.

The pins are registered. A pin reflects the inputs sampled at the clock edge that loads it.

Top module: `pwm_outstage`

## Requirements
- R1: In complementary mode (`pin_mode` 2'b00 or 2'b11) with zero dead time and no override, `out_hi` follows `raw_pwm` and `out_lo` follows its inverse, one clock after sampling. The two pins are never 1 together.
- R2: In complementary mode each side's turn-on waits D cycles after its own desired level rises. D is `dt_hi` for the high side and `dt_lo` for the low side, and D is captured when the level rises. Turn-off follows in the next cycle.
- R3: Only bits [10:0] of `dt_hi` and `dt_lo` count. Bits [13:11] are ignored, and the longest delay is 2047 cycles.
- R4: The delay count restarts on every raw edge. A desired-active run no longer than D cycles never drives its pin.
- R5: In independent mode (`pin_mode` 2'b01) both pins copy `raw_pwm`, with no dead time.
- R6: In push-pull mode (`pin_mode` 2'b10), `steer` toggles on each `cyc_start` pulse, and this takes effect in that same edge. The raw pulse goes to `out_hi` while the new steer value is 0 and to `out_lo` while it is 1. `steer` stays 0 in the other modes.
- R7: Override priority, strongest first: `dbg_halt`, `flt_act`, `clim_act`, `ffwd_act`, then the software override. An active level forces {`out_hi`,`out_lo`} to its 2-bit state, with bit 1 for the high pin and bit 0 for the low pin.
- R8: The software override has a per-pin enable. `sw_en` bit 1 replaces the high pin with `sw_val` bit 1, and bit 0 does the same for the low pin. A pin whose enable is clear keeps its normal drive.
- R9: A pulse on `sw_wr` stores `sw_en` and `sw_val` in a staging copy. When `sw_now`=1 the live copy takes the written values in the same edge. Otherwise the live copy loads the staging copy on the next `cyc_start`; a write in that same edge is included.
- R10: In complementary mode, any resolved pin state of 2'b11 is replaced by 2'b00. Independent and push-pull modes pass 2'b11 through.
- R11: While `rst_n` is low, both pins and `steer` read 0, and the software override copies clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_pwm | input | 1 | Raw PWM waveform |
| cyc_start | input | 1 | Start-of-cycle pulse |
| pin_mode | input | 2 | 00/11 complementary, 01 independent, 10 push-pull |
| dt_hi | input | 14 | High-side turn-on delay, bits [10:0] used |
| dt_lo | input | 14 | Low-side turn-on delay, bits [10:0] used |
| dbg_halt | input | 1 | Debug-halt override active |
| dbg_state | input | 2 | Pin state for debug halt {hi,lo} |
| flt_act | input | 1 | Fault override active |
| flt_state | input | 2 | Pin state for fault {hi,lo} |
| clim_act | input | 1 | Current-limit override active |
| clim_state | input | 2 | Pin state for current limit {hi,lo} |
| ffwd_act | input | 1 | Feed-forward override active |
| ffwd_state | input | 2 | Pin state for feed-forward {hi,lo} |
| sw_wr | input | 1 | Software override write strobe |
| sw_en | input | 2 | Software override enables {hi,lo} |
| sw_val | input | 2 | Software override values {hi,lo} |
| sw_now | input | 1 | 1: apply a write at once; 0: apply at start of cycle |
| out_hi | output | 1 | High-side pin drive |
| out_lo | output | 1 | Low-side pin drive |
| steer | output | 1 | Push-pull half indicator |

## Verification
Two events can land on the same edge, and the tests aim at both. The first is a software override write in staged mode arriving together with a start-of-cycle pulse. In that case the value just written must reach the pins, not the older staged value. The second is a push-pull steer toggle at the same edge as a raw rising edge. In that case the pulse must go to the half selected by the new steer value. Directed sequences set up both coincidences on purpose. Random runs then mix writes, start pulses, mode changes and stacked overrides. Every cycle, the pins and `steer` are compared with a bench model built from the requirements.

// File: rtl/pwm_os_pkg.sv
package pwm_os_pkg;

    typedef enum logic [1:0] {
        OM_COMP     = 2'b00,
        OM_INDEP    = 2'b01,
        OM_PUSHPULL = 2'b10,
        OM_COMP_ALT = 2'b11
    } pin_mode_e;

    // bit 1 = high pin, bit 0 = low pin
    typedef logic [1:0] pin_pair_t;

    typedef struct packed {
        logic      active;
        pin_pair_t state;
    } ovr_level_t;

    function automatic logic mode_is_comp(input pin_mode_e m);
        return (m == OM_COMP) || (m == OM_COMP_ALT);
    endfunction

endpackage

// File: rtl/pwm_dt_delay.sv
module pwm_dt_delay #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want,
    input  logic             bypass,
    input  logic [CNT_W-1:0] delay,
    output logic             drive_nx
);

    typedef struct packed {
        logic             prev;
        logic [CNT_W-1:0] cnt;
    } dt_state_t;

    dt_state_t st_d, st_q;
    logic      active;

    always_comb begin
        st_d      = st_q;
        st_d.prev = want;
        active    = 1'b0;
        if (!want) begin
            st_d.cnt = '0;
        end else if (!st_q.prev) begin
            // new rising edge: capture delay, restart count
            st_d.cnt = delay;
            active   = (delay == '0);
        end else if (st_q.cnt <= CNT_W'(1)) begin
            st_d.cnt = '0;
            active   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
        drive_nx = bypass ? want : active;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_swovr_buf.sv
module pwm_swovr_buf #(
    parameter int PINS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [PINS-1:0] wr_en,
    input  logic [PINS-1:0] wr_val,
    input  logic            apply_now,
    input  logic            soc,
    output logic [PINS-1:0] en_nx,
    output logic [PINS-1:0] val_nx
);

    typedef struct packed {
        logic [PINS-1:0] stage_en;
        logic [PINS-1:0] stage_val;
        logic [PINS-1:0] live_en;
        logic [PINS-1:0] live_val;
    } swb_state_t;

    swb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.stage_en  = wr_en;
            st_d.stage_val = wr_val;
        end
        if (wr && apply_now) begin
            st_d.live_en  = wr_en;
            st_d.live_val = wr_val;
        end else if (soc) begin
            st_d.live_en  = st_d.stage_en;
            st_d.live_val = st_d.stage_val;
        end
        en_nx  = st_d.live_en;
        val_nx = st_d.live_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pwm_ovr_resolve.sv
module pwm_ovr_resolve
    import pwm_os_pkg::*;
#(
    parameter int NUM_HW = 4
) (
    input  pin_pair_t               base,
    input  ovr_level_t [NUM_HW-1:0] hw_lvl,   // index NUM_HW-1 strongest
    input  pin_pair_t               sw_en,
    input  pin_pair_t               sw_val,
    input  logic                    comp,
    output pin_pair_t               pins
);

    pin_pair_t merged;

    always_comb begin
        for (int b = 0; b < 2; b++) begin
            merged[b] = sw_en[b] ? sw_val[b] : base[b];
        end
        // walk weakest to strongest so the strongest active level wins
        for (int i = 0; i < NUM_HW; i++) begin
            if (hw_lvl[i].active) merged = hw_lvl[i].state;
        end
        pins = (comp && (merged == 2'b11)) ? 2'b00 : merged;
    end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage
    import pwm_os_pkg::*;
#(
    parameter int DT_W     = 14,
    parameter int DT_CNT_W = 11
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_pwm,
    input  logic            cyc_start,
    input  logic [1:0]      pin_mode,
    input  logic [DT_W-1:0] dt_hi,
    input  logic [DT_W-1:0] dt_lo,
    input  logic            dbg_halt,
    input  logic [1:0]      dbg_state,
    input  logic            flt_act,
    input  logic [1:0]      flt_state,
    input  logic            clim_act,
    input  logic [1:0]      clim_state,
    input  logic            ffwd_act,
    input  logic [1:0]      ffwd_state,
    input  logic            sw_wr,
    input  logic [1:0]      sw_en,
    input  logic [1:0]      sw_val,
    input  logic            sw_now,
    output logic            out_hi,
    output logic            out_lo,
    output logic            steer
);

    localparam int NUM_HW = 4;
    localparam int SIDES  = 2;

    typedef struct packed {
        pin_pair_t pins;
        logic      steer;
    } os_state_t;

    os_state_t st_d, st_q;

    pin_mode_e  mode;
    logic       comp, pushpull, indep;
    logic       steer_eff;
    logic [SIDES-1:0] want;
    logic [SIDES-1:0] drive;
    logic [DT_CNT_W-1:0] dly [SIDES];
    pin_pair_t  sw_en_nx, sw_val_nx, pins_nx;
    ovr_level_t [NUM_HW-1:0] hw_lvl;
    logic       dt_unused_bits;

    assign mode     = pin_mode_e'(pin_mode);
    assign comp     = mode_is_comp(mode);
    assign pushpull = (mode == OM_PUSHPULL);
    assign indep    = (mode == OM_INDEP);

    assign dly[1] = dt_hi[DT_CNT_W-1:0];
    assign dly[0] = dt_lo[DT_CNT_W-1:0];
    assign dt_unused_bits = ^{dt_hi[DT_W-1:DT_CNT_W], dt_lo[DT_W-1:DT_CNT_W]};

    always_comb begin
        steer_eff = pushpull ? (st_q.steer ^ cyc_start) : 1'b0;
        if (indep) begin
            want = {raw_pwm, raw_pwm};
        end else if (pushpull) begin
            want = {raw_pwm & ~steer_eff, raw_pwm & steer_eff};
        end else begin
            want = {raw_pwm, ~raw_pwm};
        end
    end

    generate
        for (genvar gs = 0; gs < SIDES; gs++) begin : g_side
            pwm_dt_delay #(.CNT_W(DT_CNT_W)) i_dt (
                .clk      (clk),
                .rst_n    (rst_n),
                .want     (want[gs]),
                .bypass   (~comp),
                .delay    (dly[gs]),
                .drive_nx (drive[gs])
            );
        end
    endgenerate

    pwm_swovr_buf #(.PINS(2)) i_swbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (sw_wr),
        .wr_en     (sw_en),
        .wr_val    (sw_val),
        .apply_now (sw_now),
        .soc       (cyc_start),
        .en_nx     (sw_en_nx),
        .val_nx    (sw_val_nx)
    );

    // index 0 weakest ... NUM_HW-1 strongest
    assign hw_lvl[0] = '{active: ffwd_act, state: ffwd_state};
    assign hw_lvl[1] = '{active: clim_act, state: clim_state};
    assign hw_lvl[2] = '{active: flt_act,  state: flt_state};
    assign hw_lvl[3] = '{active: dbg_halt, state: dbg_state};

    pwm_ovr_resolve #(.NUM_HW(NUM_HW)) i_resolve (
        .base   (drive),
        .hw_lvl (hw_lvl),
        .sw_en  (sw_en_nx),
        .sw_val (sw_val_nx),
        .comp   (comp),
        .pins   (pins_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pins  = pins_nx;
        st_d.steer = steer_eff;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_hi = st_q.pins[1];
    assign out_lo = st_q.pins[0];
    assign steer  = st_q.steer;

endmodule

// File: rtl/pwm_outstage_chk.sv
module pwm_outstage_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_start,
    input logic [1:0] pin_mode,
    input logic       dbg_halt,
    input logic [1:0] dbg_state,
    input logic       flt_act,
    input logic [1:0] flt_state,
    input logic       out_hi,
    input logic       out_lo,
    input logic       steer
);

    // R10: complementary pins never both active
    assert_comp_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(pin_mode) == 2'b00 || $past(pin_mode) == 2'b11))
        |-> !(out_hi && out_lo));

    // R7: debug halt state wins
    assert_dbg_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && dbg_halt && (dbg_state != 2'b11 || pin_mode == 2'b01 || pin_mode == 2'b10))
        |-> ({out_hi, out_lo} == $past(dbg_state)));

    // R7: fault wins when debug halt is idle
    assert_flt_below_dbg_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && !dbg_halt && flt_act && (flt_state != 2'b11 || pin_mode == 2'b01 || pin_mode == 2'b10))
        |-> ({out_hi, out_lo} == $past(flt_state)));

    // R6: steer idle outside push-pull
    assert_steer_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pin_mode) != 2'b10) |-> !steer);

    // R6: steer flips on start of cycle in push-pull
    assert_steer_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && pin_mode == 2'b10 && cyc_start) |-> (steer != $past(steer)));

    // R11: reset holds pins low
    assert_reset_quiet_R11: assert property (@(posedge clk)
        !rst_n |-> (!out_hi && !out_lo && !steer));

endmodule

bind pwm_outstage pwm_outstage_chk i_chk (.*);

// File: tb/test_pwm_outstage.sv
module test_pwm_outstage;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        raw_pwm = 1'b0, cyc_start = 1'b0;
    logic [1:0]  pin_mode = 2'b00;
    logic [13:0] dt_hi = '0, dt_lo = '0;
    logic        dbg_halt = 1'b0, flt_act = 1'b0, clim_act = 1'b0, ffwd_act = 1'b0;
    logic [1:0]  dbg_state = '0, flt_state = '0, clim_state = '0, ffwd_state = '0;
    logic        sw_wr = 1'b0, sw_now = 1'b0;
    logic [1:0]  sw_en = '0, sw_val = '0;
    logic        out_hi, out_lo, steer;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done = 0;

    // bench model state
    int        m_run_hi, m_run_lo, m_dhi, m_dlo;
    bit        m_steer;
    bit [1:0]  m_stage_en, m_stage_val, m_live_en, m_live_val;
    bit [1:0]  exp_pins;
    bit        exp_steer;
    string     dir_tag = "";
    string     cur_tag = "";

    always #10 clk = ~clk;   // 50 MHz

    pwm_outstage i_pwm_outstage (.*);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic model_step();
        bit indep, pp, comp, se, wh, wl, ah, al;
        bit [1:0] base, res;
        if (!rst_n) begin
            m_run_hi = 0; m_run_lo = 0; m_dhi = 0; m_dlo = 0; m_steer = 0;
            m_stage_en = 0; m_stage_val = 0; m_live_en = 0; m_live_val = 0;
            exp_pins = 0; exp_steer = 0;
            cur_tag = "R11";
            return;
        end
        indep = (pin_mode == 2'b01);
        pp    = (pin_mode == 2'b10);
        comp  = !indep && !pp;
        se    = pp ? (m_steer ^ cyc_start) : 1'b0;
        wh = indep ? raw_pwm : pp ? (raw_pwm & !se) : raw_pwm;
        wl = indep ? raw_pwm : pp ? (raw_pwm & se)  : !raw_pwm;
        if (wh) begin
            if (m_run_hi == 0) m_dhi = int'(dt_hi[10:0]);
            if (m_run_hi < 4095) m_run_hi++;
        end else m_run_hi = 0;
        if (wl) begin
            if (m_run_lo == 0) m_dlo = int'(dt_lo[10:0]);
            if (m_run_lo < 4095) m_run_lo++;
        end else m_run_lo = 0;
        ah = wh && (m_run_hi >= m_dhi + 1);
        al = wl && (m_run_lo >= m_dlo + 1);
        base = comp ? {ah, al} : {wh, wl};
        if (sw_wr && sw_now) begin
            m_live_en = sw_en; m_live_val = sw_val;
        end else if (cyc_start) begin
            m_live_en  = sw_wr ? sw_en  : m_stage_en;
            m_live_val = sw_wr ? sw_val : m_stage_val;
        end
        if (sw_wr) begin
            m_stage_en = sw_en; m_stage_val = sw_val;
        end
        res[1] = m_live_en[1] ? m_live_val[1] : base[1];
        res[0] = m_live_en[0] ? m_live_val[0] : base[0];
        if (ffwd_act) res = ffwd_state;
        if (clim_act) res = clim_state;
        if (flt_act)  res = flt_state;
        if (dbg_halt) res = dbg_state;
        if (comp && res == 2'b11) res = 2'b00;
        exp_pins  = res;
        m_steer   = se;
        exp_steer = se;
        if (dir_tag != "") cur_tag = dir_tag;
        else if (dbg_halt || flt_act || clim_act || ffwd_act) cur_tag = "R7";
        else if (m_live_en != 0) cur_tag = "R8";
        else if (comp) cur_tag = "R2";
        else if (indep) cur_tag = "R5";
        else cur_tag = "R6";
    endtask

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        checks++;
        if ({out_hi, out_lo} !== exp_pins || steer !== exp_steer) begin
            errors++;
            $display("FAIL %s: actual hi=%b lo=%b steer=%b expected hi=%b lo=%b steer=%b",
                     cur_tag, out_hi, out_lo, steer, exp_pins[1], exp_pins[0], exp_steer);
        end
        cyc_start = 1'b0;
        sw_wr     = 1'b0;
    endtask

    task automatic raw_run(input bit v, input int n);
        for (int i = 0; i < n; i++) begin
            raw_pwm = v;
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R11: reset state
        dir_tag = "R11";
        raw_pwm = 1'b1; pin_mode = 2'b01;
        repeat (3) step();
        raw_pwm = 1'b0; pin_mode = 2'b00;
        rst_n = 1'b1;

        // R1: complementary follow with zero delay
        dir_tag = "R1";
        raw_run(0, 2); raw_run(1, 2); raw_run(0, 1); raw_run(1, 1); raw_run(0, 3);

        // R2: separate rising delays
        dir_tag = "R2";
        dt_hi = 14'd3; dt_lo = 14'd5;
        raw_run(1, 10); raw_run(0, 10); raw_run(1, 4); raw_run(0, 8);

        // R3: upper bits ignored, maximum delay
        dir_tag = "R3";
        dt_hi = 14'h3805; dt_lo = 14'h0000;
        raw_run(1, 10); raw_run(0, 4);
        dt_hi = 14'h07FF;
        raw_run(1, 2100); raw_run(0, 4);

        // R4: short pulses swallowed, restart per edge
        dir_tag = "R4";
        dt_hi = 14'd4; dt_lo = 14'd2;
        raw_run(1, 3); raw_run(0, 2); raw_run(1, 4); raw_run(0, 1); raw_run(1, 6); raw_run(0, 5);

        // R5: independent mode
        dir_tag = "R5";
        pin_mode = 2'b01;
        raw_run(1, 3); raw_run(0, 2); raw_run(1, 1); raw_run(0, 2);

        // R6: push-pull alternation, soc coincident with rising edge
        dir_tag = "R6";
        pin_mode = 2'b10;
        for (int c = 0; c < 6; c++) begin
            raw_pwm = 1'b1; cyc_start = 1'b1; step();
            raw_run(1, 2); raw_run(0, 2);
        end

        // R7: stacked hardware overrides
        dir_tag = "R7";
        pin_mode = 2'b01; raw_pwm = 1'b1;
        ffwd_act = 1; ffwd_state = 2'b01; step();
        clim_act = 1; clim_state = 2'b10; step();
        flt_act = 1;  flt_state = 2'b00;  step();
        dbg_halt = 1; dbg_state = 2'b11;  step();
        dbg_halt = 0; step();
        flt_act = 0;  step();
        clim_act = 0; step();
        ffwd_act = 0; step();

        // R8: per-pin software enables
        dir_tag = "R8";
        raw_pwm = 1'b0;
        sw_wr = 1; sw_now = 1; sw_en = 2'b10; sw_val = 2'b10; step();
        step();
        raw_pwm = 1'b1;
        sw_wr = 1; sw_en = 2'b01; sw_val = 2'b00; step();
        step();

        // R9: staged vs immediate, write coincident with soc
        dir_tag = "R9";
        pin_mode = 2'b00; dt_hi = 0; dt_lo = 0; raw_pwm = 1'b0;
        sw_wr = 1; sw_now = 1; sw_en = 2'b00; sw_val = 2'b00; step();
        sw_now = 0;
        sw_wr = 1; sw_en = 2'b11; sw_val = 2'b10; step();
        step(); step();
        cyc_start = 1; step();
        step();
        sw_wr = 1; sw_en = 2'b11; sw_val = 2'b01; cyc_start = 1; step();
        sw_wr = 1; sw_en = 2'b11; sw_val = 2'b10; step();
        step();
        sw_wr = 1; sw_now = 1; sw_en = 2'b00; step();
        step();

        // R10: forbidden pair in complementary mode
        dir_tag = "R10";
        dbg_halt = 1; dbg_state = 2'b11; step();
        pin_mode = 2'b01; step();
        pin_mode = 2'b10; step();
        dbg_halt = 0; pin_mode = 2'b00; step();

        // random mix
        dir_tag = "";
        sw_now = 0;
        for (int seg = 0; seg < 40; seg++) begin
            int per, pc;
            pin_mode = 2'($urandom_range(0, 3));
            dt_hi = 14'($urandom_range(0, 7)) | (14'($urandom_range(0, 7)) << 11);
            dt_lo = 14'($urandom_range(0, 7)) | (14'($urandom_range(0, 7)) << 11);
            sw_now = 1'($urandom_range(0, 1));
            per = $urandom_range(6, 20);
            pc = 0;
            for (int k = 0; k < 500; k++) begin
                if ($urandom_range(0, 3) == 0) raw_pwm = ~raw_pwm;
                pc++;
                if (pc >= per) begin cyc_start = 1; pc = 0; end
                dbg_halt = ($urandom_range(0, 40) == 0);
                flt_act  = ($urandom_range(0, 20) == 0);
                clim_act = ($urandom_range(0, 15) == 0);
                ffwd_act = ($urandom_range(0, 12) == 0);
                dbg_state  = 2'($urandom); flt_state  = 2'($urandom);
                clim_state = 2'($urandom); ffwd_state = 2'($urandom);
                if ($urandom_range(0, 9) == 0) begin
                    sw_wr = 1;
                    sw_en = ($urandom_range(0, 2) == 0) ? 2'($urandom) : 2'b00;
                    sw_val = 2'($urandom);
                end
                step();
            end
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule